// File: doc/BRIEF.md
# Command/Address Parity Register

This block is the single pipeline stage that sits between a memory controller and the DRAM devices of a registered memory module. Every clock edge it samples the address, bank address and the three command strobes, along with per-rank chip selects, clock enables and termination enables. It presents them one cycle later on the DRAM-facing side.

In the same cycle it checks even parity over the command/address word together with a parity input bit. The result is reported one cycle later, aligned with the forwarded command, through an open-drain style pull-low enable and its active-low companion. A sticky status bit records that at least one error has been seen.

A particular command pattern is not meant for the DRAMs. It is treated as a write to a small bank of internal configuration words instead. The DRAM chip selects are held inactive for that cycle. The write is committed only when its parity is good. Ordinary DRAM commands are always forwarded, whatever their parity.

Top module: `cmd_par_reg`

## Requirements
- R1: `dram_addr`, `dram_ba`, `dram_ras_n`, `dram_cas_n` and `dram_we_n` show the values that the matching `cmd_*` inputs held at the previous rising clock edge.
- R2: For each rank i, `dram_cke[i]` and `dram_odt[i]` show `cmd_cke[i]` and `cmd_odt[i]` from the previous edge. `dram_cs_n[i]` shows `cmd_cs_n[i]` from the previous edge, except in the case of R8.
- R3: The parity set is `cmd_addr[15:0]`, `cmd_ba[2:0]`, `cmd_ras_n`, `cmd_cas_n`, `cmd_we_n` and `cmd_par`. It is good when its count of ones is even. An odd count sampled while any chip select is low drives `perr_pull` high and `perr_n` low for exactly the one cycle in which the command appears on the outputs.
- R4: A DRAM command with bad parity is still forwarded unchanged, as stated in R1 and R2.
- R5: When every `cmd_cs_n` bit is high, no parity check is made, and `perr_pull` stays low whatever the parity.
- R6: A control-word write is a cycle in which every `cmd_cs_n` bit is low and `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` are all low.
  - The word index is `cmd_addr[3:0]`.
  - The data is `cmd_addr[7:4]`.
  - Word k appears on `cfg_words[4k+3:4k]` from the cycle after the edge, provided parity is good.
- R7: A control-word write with bad parity leaves every configuration word unchanged, and it raises the error of R3.
- R8: In the output cycle of a control-word write, every `dram_cs_n` bit is high, so no rank sees the command.
- R9: `perr_sticky` goes high together with any `perr_pull` pulse, and it stays high until reset.
- R10: A synchronous active-high `rst` sets the following values:
  - `dram_addr`, `dram_ba`, `dram_cke` and `dram_odt` to zero;
  - `dram_ras_n`, `dram_cas_n`, `dram_we_n` and every `dram_cs_n` bit to one;
  - `perr_pull` and `perr_sticky` to zero, and `perr_n` to one;
  - every configuration word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_addr | input | 16 | Address from the controller |
| cmd_ba | input | 3 | Bank address from the controller |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write enable, active low |
| cmd_cs_n | input | RANKS | Per-rank chip selects, active low |
| cmd_cke | input | RANKS | Per-rank clock enables |
| cmd_odt | input | RANKS | Per-rank termination enables |
| cmd_par | input | 1 | Parity bit over the command/address word |
| dram_addr | output | 16 | Registered address |
| dram_ba | output | 3 | Registered bank address |
| dram_ras_n | output | 1 | Registered row strobe |
| dram_cas_n | output | 1 | Registered column strobe |
| dram_we_n | output | 1 | Registered write enable |
| dram_cs_n | output | RANKS | Registered chip selects, forced high on control-word writes |
| dram_cke | output | RANKS | Registered clock enables |
| dram_odt | output | RANKS | Registered termination enables |
| perr_pull | output | 1 | Pull-low enable of the open-drain error line |
| perr_n | output | 1 | Active-low parity error level |
| perr_sticky | output | 1 | Error seen since reset |
| cfg_words | output | 2^CW_IDX_W * CW_DATA_W | Configuration words, word k at bits [k*CW_DATA_W +: CW_DATA_W] |

## Verification
The bench builds the block with its defaults: two ranks, sixteen configuration words and four data bits per word. With two ranks, it can drive patterns in which one rank is selected and the other is not. Those patterns separate a parity-checked DRAM command from a control-word write, which needs both selects low.

Sixteen words let a sweep write every index with a distinct value. A later bad-parity write to a chosen index can then be seen to leave its neighbours and itself untouched.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    localparam int ADDR_W = 16;
    localparam int BA_W   = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
    } ca_word_t;

    localparam int CA_W = $bits(ca_word_t);

    localparam ca_word_t CA_IDLE = '{addr: '0, ba: '0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // High when the word plus the parity bit has an odd number of ones.
    function automatic logic parity_odd(ca_word_t w, logic par);
        return ^{w, par};
    endfunction

    // Register-targeted write: all ranks selected and all three strobes low.
    function automatic logic cw_pattern(ca_word_t w, logic all_sel);
        return all_sel & ~w.ras_n & ~w.cas_n & ~w.we_n;
    endfunction
endpackage

// File: rtl/cpr_parity.sv
module cpr_parity
    import cpr_pkg::*;
#(
    parameter int RANKS = 2
) (
    input  ca_word_t         ca,
    input  logic             par,
    input  logic [RANKS-1:0] cs_n,
    output logic             par_err,
    output logic             cw_req,
    output logic             cw_commit
);
    logic any_sel;
    logic all_sel;
    logic odd;

    always_comb begin
        any_sel   = ~&cs_n;
        all_sel   = ~|cs_n;
        odd       = parity_odd(ca, par);
        par_err   = any_sel & odd;
        cw_req    = cw_pattern(ca, all_sel);
        cw_commit = cw_req & ~odd;
    end
endmodule

// File: rtl/cpr_cw_bank.sv
module cpr_cw_bank
    import cpr_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  ca_word_t                         ca,
    output logic [(1<<IDX_W)*DATA_W-1:0]     words
);
    localparam int NWORDS = 1 << IDX_W;

    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;

    always_comb begin
        wr_idx  = ca.addr[IDX_W-1:0];
        wr_data = ca.addr[IDX_W +: DATA_W];
    end

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                word_q <= wr_data;
            end
        end
        assign words[k*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/cpr_pipe.sv
module cpr_pipe
    import cpr_pkg::*;
#(
    parameter int RANKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  ca_word_t         ca_in,
    input  logic [RANKS-1:0] cs_n_in,
    input  logic [RANKS-1:0] cke_in,
    input  logic [RANKS-1:0] odt_in,
    input  logic             cw_req,
    input  logic             par_err,
    output ca_word_t         ca_q,
    output logic [RANKS-1:0] cs_n_q,
    output logic [RANKS-1:0] cke_q,
    output logic [RANKS-1:0] odt_q,
    output logic             err_q,
    output logic             sticky_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ca_q     <= CA_IDLE;
            err_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            ca_q     <= ca_in;
            err_q    <= par_err;
            sticky_q <= sticky_q | par_err;
        end
    end

    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        always_ff @(posedge clk) begin
            if (rst) begin
                cs_n_q[r] <= 1'b1;
                cke_q[r]  <= 1'b0;
                odt_q[r]  <= 1'b0;
            end else begin
                cs_n_q[r] <= cs_n_in[r] | cw_req;
                cke_q[r]  <= cke_in[r];
                odt_q[r]  <= odt_in[r];
            end
        end
    end
endmodule

// File: rtl/cmd_par_reg.sv
module cmd_par_reg
    import cpr_pkg::*;
#(
    parameter int RANKS     = 2,
    parameter int CW_IDX_W  = 4,
    parameter int CW_DATA_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [15:0]                           cmd_addr,
    input  logic [2:0]                            cmd_ba,
    input  logic                                  cmd_ras_n,
    input  logic                                  cmd_cas_n,
    input  logic                                  cmd_we_n,
    input  logic [RANKS-1:0]                      cmd_cs_n,
    input  logic [RANKS-1:0]                      cmd_cke,
    input  logic [RANKS-1:0]                      cmd_odt,
    input  logic                                  cmd_par,
    output logic [15:0]                           dram_addr,
    output logic [2:0]                            dram_ba,
    output logic                                  dram_ras_n,
    output logic                                  dram_cas_n,
    output logic                                  dram_we_n,
    output logic [RANKS-1:0]                      dram_cs_n,
    output logic [RANKS-1:0]                      dram_cke,
    output logic [RANKS-1:0]                      dram_odt,
    output logic                                  perr_pull,
    output logic                                  perr_n,
    output logic                                  perr_sticky,
    output logic [(1<<CW_IDX_W)*CW_DATA_W-1:0]    cfg_words
);
    ca_word_t ca_in;
    ca_word_t ca_q;
    logic     par_err;
    logic     cw_req;
    logic     cw_commit;

    always_comb begin
        ca_in.addr  = cmd_addr;
        ca_in.ba    = cmd_ba;
        ca_in.ras_n = cmd_ras_n;
        ca_in.cas_n = cmd_cas_n;
        ca_in.we_n  = cmd_we_n;
    end

    cpr_parity #(.RANKS(RANKS)) parity_i (
        .ca        (ca_in),
        .par       (cmd_par),
        .cs_n      (cmd_cs_n),
        .par_err   (par_err),
        .cw_req    (cw_req),
        .cw_commit (cw_commit)
    );

    cpr_pipe #(.RANKS(RANKS)) pipe_i (
        .clk      (clk),
        .rst      (rst),
        .ca_in    (ca_in),
        .cs_n_in  (cmd_cs_n),
        .cke_in   (cmd_cke),
        .odt_in   (cmd_odt),
        .cw_req   (cw_req),
        .par_err  (par_err),
        .ca_q     (ca_q),
        .cs_n_q   (dram_cs_n),
        .cke_q    (dram_cke),
        .odt_q    (dram_odt),
        .err_q    (perr_pull),
        .sticky_q (perr_sticky)
    );

    cpr_cw_bank #(.IDX_W(CW_IDX_W), .DATA_W(CW_DATA_W)) cw_bank_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cw_commit),
        .ca    (ca_in),
        .words (cfg_words)
    );

    always_comb begin
        dram_addr  = ca_q.addr;
        dram_ba    = ca_q.ba;
        dram_ras_n = ca_q.ras_n;
        dram_cas_n = ca_q.cas_n;
        dram_we_n  = ca_q.we_n;
        perr_n     = ~perr_pull;
    end
endmodule

// File: rtl/cmd_par_reg_chk.sv
module cmd_par_reg_chk #(
    parameter int RANKS = 2,
    parameter int CFG_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [15:0]      cmd_addr,
    input logic [2:0]       cmd_ba,
    input logic             cmd_ras_n,
    input logic             cmd_cas_n,
    input logic             cmd_we_n,
    input logic [RANKS-1:0] cmd_cs_n,
    input logic             cmd_par,
    input logic [15:0]      dram_addr,
    input logic [RANKS-1:0] dram_cs_n,
    input logic             perr_pull,
    input logic             perr_sticky,
    input logic [CFG_W-1:0] cfg_words
);
    logic in_odd;
    logic in_cw;

    always_comb begin
        in_odd = ^{cmd_addr, cmd_ba, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_par};
        in_cw  = (cmd_cs_n == '0) && !cmd_ras_n && !cmd_cas_n && !cmd_we_n;
    end

    // R1 and R4: the address is forwarded one cycle later, whatever its parity
    a_r1_addr_forward: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> dram_addr == $past(cmd_addr));

    a_r3_err_pulse: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> perr_pull == $past((cmd_cs_n != '1) && in_odd));

    a_r5_idle_no_err: assert property (@(posedge clk) disable iff (rst)
        (cmd_cs_n == '1) |=> !perr_pull);

    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_cw && !in_odd) |=> $stable(cfg_words));

    a_r8_cw_deselect: assert property (@(posedge clk) disable iff (rst)
        in_cw |=> dram_cs_n == '1);

    a_r9_sticky_set: assert property (@(posedge clk) disable iff (rst)
        perr_pull |-> perr_sticky);

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        perr_sticky |=> perr_sticky);
endmodule

bind cmd_par_reg cmd_par_reg_chk #(
    .RANKS (RANKS),
    .CFG_W ((1<<CW_IDX_W)*CW_DATA_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_addr    (cmd_addr),
    .cmd_ba      (cmd_ba),
    .cmd_ras_n   (cmd_ras_n),
    .cmd_cas_n   (cmd_cas_n),
    .cmd_we_n    (cmd_we_n),
    .cmd_cs_n    (cmd_cs_n),
    .cmd_par     (cmd_par),
    .dram_addr   (dram_addr),
    .dram_cs_n   (dram_cs_n),
    .perr_pull   (perr_pull),
    .perr_sticky (perr_sticky),
    .cfg_words   (cfg_words)
);

// File: tb/cmd_par_reg_tb_top.sv
module cmd_par_reg_tb_top;
    localparam int RANKS  = 2;
    localparam int IDX_W  = 4;
    localparam int DW     = 4;
    localparam int NW     = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] cmd_addr = 16'hFFFF;
    logic [2:0]  cmd_ba = 3'h7;
    logic cmd_ras_n = 1'b0, cmd_cas_n = 1'b0, cmd_we_n = 1'b0;
    logic [RANKS-1:0] cmd_cs_n = '0, cmd_cke = '1, cmd_odt = '1;
    logic cmd_par = 1'b1;

    logic [15:0] dram_addr;
    logic [2:0]  dram_ba;
    logic dram_ras_n, dram_cas_n, dram_we_n;
    logic [RANKS-1:0] dram_cs_n, dram_cke, dram_odt;
    logic perr_pull, perr_n, perr_sticky;
    logic [NW*DW-1:0] cfg_words;

    always #2 clk = ~clk;

    cmd_par_reg #(.RANKS(RANKS), .CW_IDX_W(IDX_W), .CW_DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .cmd_addr(cmd_addr), .cmd_ba(cmd_ba), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_cs_n(cmd_cs_n),
        .cmd_cke(cmd_cke), .cmd_odt(cmd_odt), .cmd_par(cmd_par),
        .dram_addr(dram_addr), .dram_ba(dram_ba), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_cs_n(dram_cs_n),
        .dram_cke(dram_cke), .dram_odt(dram_odt), .perr_pull(perr_pull),
        .perr_n(perr_n), .perr_sticky(perr_sticky), .cfg_words(cfg_words)
    );

    // Behavioural reference model, updated on every rising edge
    logic [15:0] e_addr;
    logic [2:0]  e_ba;
    logic e_ras, e_cas, e_we;
    logic [RANKS-1:0] e_cs, e_cke, e_odt;
    logic e_err, e_sticky;
    int   e_cfg [NW];
    bit   m_in_reset, m_bad_par, m_idle, m_cw, m_cw_bad;
    int   checks = 0, failures = 0, cycles = 0;

    always @(posedge clk) begin
        int ones;
        bit idle, cw, odd;
        ones = $countones({cmd_addr, cmd_ba, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_par});
        odd  = (ones % 2) == 1;
        idle = (cmd_cs_n == '1);
        cw   = (cmd_cs_n == '0) && !cmd_ras_n && !cmd_cas_n && !cmd_we_n;
        m_in_reset = rst;
        m_bad_par  = odd && !idle;
        m_idle     = idle;
        m_cw       = cw;
        m_cw_bad   = cw && odd;
        if (rst) begin
            e_addr = '0; e_ba = '0; e_ras = 1; e_cas = 1; e_we = 1;
            e_cs = '1; e_cke = '0; e_odt = '0; e_err = 0; e_sticky = 0;
            foreach (e_cfg[i]) e_cfg[i] = 0;
        end else begin
            e_addr = cmd_addr; e_ba = cmd_ba;
            e_ras = cmd_ras_n; e_cas = cmd_cas_n; e_we = cmd_we_n;
            e_cs  = cw ? '1 : cmd_cs_n;
            e_cke = cmd_cke; e_odt = cmd_odt;
            e_err = !idle && odd;
            if (e_err) e_sticky = 1;
            if (cw && !odd) e_cfg[int'(cmd_addr[3:0])] = int'(cmd_addr[7:4]);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string rf, rc, re, rg;
        rf = m_in_reset ? "R10" : (m_bad_par ? "R4" : "R1");
        rc = m_in_reset ? "R10" : (m_cw ? "R8" : "R2");
        re = m_in_reset ? "R10" : (m_idle ? "R5" : "R3");
        rg = m_in_reset ? "R10" : (m_cw_bad ? "R7" : "R6");
        chk(rf, "addr", int'(dram_addr), int'(e_addr));
        chk(rf, "ba", int'(dram_ba), int'(e_ba));
        chk(rf, "strobes", int'({dram_ras_n, dram_cas_n, dram_we_n}), int'({e_ras, e_cas, e_we}));
        chk(rc, "cs_n", int'(dram_cs_n), int'(e_cs));
        chk(m_in_reset ? "R10" : "R2", "cke", int'(dram_cke), int'(e_cke));
        chk(m_in_reset ? "R10" : "R2", "odt", int'(dram_odt), int'(e_odt));
        chk(re, "perr_pull", int'(perr_pull), int'(e_err));
        chk(re, "perr_n", int'(perr_n), int'(!e_err));
        chk(m_in_reset ? "R10" : "R9", "sticky", int'(perr_sticky), int'(e_sticky));
        for (int i = 0; i < NW; i++)
            chk(rg, $sformatf("cfg[%0d]", i), int'(cfg_words[i*DW +: DW]), e_cfg[i]);
    endtask

    function automatic logic even_par(logic [15:0] a, logic [2:0] b, logic r, logic c, logic w);
        return ^{a, b, r, c, w};
    endfunction

    task automatic step(input logic [15:0] a, input logic [2:0] b, input logic r,
                        input logic c, input logic w, input logic [RANKS-1:0] cs,
                        input logic [RANKS-1:0] ke, input logic [RANKS-1:0] ot,
                        input logic bad);
        cmd_addr = a; cmd_ba = b; cmd_ras_n = r; cmd_cas_n = c; cmd_we_n = w;
        cmd_cs_n = cs; cmd_cke = ke; cmd_odt = ot;
        cmd_par = even_par(a, b, r, c, w) ^ bad;
        @(negedge clk);
        compare_all();
    endtask

    task automatic cw_write(input int idx, input int data, input logic bad);
        step({8'h00, 4'(data), 4'(idx)}, 3'($urandom), 0, 0, 0, '0, 2'($urandom), 2'($urandom), bad);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    initial begin
        // R10: reset state with all inputs driven away from it
        repeat (3) begin
            @(negedge clk);
            compare_all();
        end
        rst = 1'b0;
        // R1 R2 R3: good parity, mixed rank selection
        for (int i = 0; i < 40; i++)
            step(16'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'b1,
                 2'($urandom_range(0, 2)), 2'($urandom), 2'($urandom), 1'b0);
        // R5: deselected cycles with bad parity
        for (int i = 0; i < 10; i++)
            step(16'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 '1, 2'($urandom), 2'($urandom), 1'b1);
        // R3 R4: single-rank commands with bad parity are forwarded
        step(16'hA5C3, 3'h5, 0, 1, 1, 2'b10, 2'b11, 2'b01, 1'b1);
        step(16'h1234, 3'h2, 1, 0, 1, 2'b01, 2'b10, 2'b10, 1'b1);
        step(16'h0000, 3'h0, 0, 0, 0, 2'b10, 2'b01, 2'b00, 1'b1);
        step(16'hFFFF, 3'h7, 1, 1, 1, 2'b01, 2'b11, 2'b11, 1'b0);
        // R6 R8: fill every configuration word
        for (int k = 0; k < NW; k++) cw_write(k, (k * 7 + 3) % 16, 1'b0);
        step(16'h0000, 3'h0, 1, 1, 1, '1, 2'b00, 2'b00, 1'b0);
        // R7: bad-parity control writes are dropped
        cw_write(5, 4'hF ^ ((5 * 7 + 3) % 16), 1'b1);
        cw_write(0, 4'hE, 1'b1);
        cw_write(15, 4'h1, 1'b1);
        step(16'h0000, 3'h0, 1, 1, 1, '1, 2'b00, 2'b00, 1'b0);
        // R6: overwrite after a dropped write
        cw_write(5, 4'h9, 1'b0);
        // Mixed traffic with random parity
        for (int i = 0; i < 120; i++)
            step(16'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
        // R10 R9: reset mid-run clears sticky and words
        rst = 1'b1;
        step(16'h5A5A, 3'h3, 0, 0, 0, '0, '1, '1, 1'b1);
        step(16'h5A5A, 3'h3, 0, 0, 0, '0, '1, '1, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 60; i++)
            step(16'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
        finish_run();
    end
endmodule